// File: doc/BRIEF.md
# Multi-Operand Adder with Generalized-Counter Reduction

This block sums N unsigned operands of W bits each in a single combinational pass and returns the exact total. The operands arrive packed side by side in one vector. Inside, their bits are treated as dots sorted into columns by binary weight. A sequence of reduction stages then shrinks the columns until no column is taller than three dots. Each stage places generalized parallel counters: small cells that count input bits of rank 0 and rank 1 together and emit the weighted count in binary. Every cell has at most six inputs, so each of its output bits is one six-input function.

Cells are placed greedily. The tallest column is covered first, using the cell shape with the best ratio of inputs to outputs that fits. Dots that no cell takes pass straight through to the next stage. When at most three rows are left, one three-operand carry-propagate add produces the result.

The result is driven combinationally on one port. It is also captured into an output register on any clock edge where the load enable is high.

Top module: `adderTree`

## Requirements
- R1: `sumNow` equals the exact unsigned sum of the N operands, where operand k occupies bits [k·W+W-1 : k·W] of `operands`. The result is ceil(log2(N·(2^W−1)+1)) bits wide, which is 11 bits for the default N=8, W=8.
- R2: `sumNow` follows a change on `operands` within the same cycle, with no clock edge needed.
- R3: The counter cell shapes are numbered 0 to 5. Each shape has k0 rank-0 inputs and k1 rank-1 inputs, listed as (k1,k0;outputs): 0=(0,6;3), 1=(1,5;3), 2=(2,3;3), 3=(1,4;3), 4=(0,5;3), 5=(0,3;2). In a 6-bit input pattern, bits [k0-1:0] are rank 0 and the next k1 bits are rank 1. For every such pattern, the cell returns the number of rank-0 ones plus twice the number of rank-1 ones.
- R4: Every cell shape meets all of these limits: at most six inputs, at least two rank-0 inputs, fewer outputs than inputs, and enough outputs to hold its largest weighted count.
- R5: Each reduction stage keeps the weighted value of all dots unchanged.
- R6: After the last reduction stage, no column holds more than three dots, and at least one stage is used for the default parameters.
- R7: On a rising clock edge with `loadEn` high, `sumReg` takes the value `sumNow` had just before that edge.
- R8: While `loadEn` is low, `sumReg` keeps its value whatever `operands` does.
- R9: While `rstN` is low, `sumReg` is zero.
- R10: N all-ones operands produce N·(2^W−1), which is 2040 for the defaults, with no loss of the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| operands | input | N·W | Packed unsigned operands, operand k at bits k·W and up |
| loadEn | input | 1 | Captures the sum into the output register |
| sumNow | output | SUMW | Combinational exact sum |
| sumReg | output | SUMW | Registered sum |

## Verification
Several internal faults all reach `sumNow` in the same cycle as the operands that expose them: a wrong counter output, a misrouted dot or a dropped carry out of a high column. A single misplaced dot shifts the total by a power of two, so walking single-bit operands locate the fault by column. All-ones operands stress the tallest columns and the top result bit. A register fault shows on `sumReg` one edge after a load, or as drift during cycles where the load enable is low.

// File: rtl/gpcTreePkg.sv
`timescale 1ns/1ps
package gpcTreePkg;

  localparam int MAX_COLS = 64;
  localparam int LIB_SIZE = 6;

  // Per-column dot counts, one byte per column.
  typedef logic [MAX_COLS-1:0][7:0] heightArr_t;

  typedef struct packed {
    logic capture;
  } treeStrobe_t;

  // Cell library, best compression ratio first.
  function automatic int libRank0(input int g);
    case (g)
      0: return 6;
      1: return 5;
      2: return 3;
      3: return 4;
      4: return 5;
      default: return 3;
    endcase
  endfunction

  function automatic int libRank1(input int g);
    case (g)
      1: return 1;
      2: return 2;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int libOuts(input int g);
    return (g == 5) ? 2 : 3;
  endfunction

  function automatic int sumWidth(input int n, input int w);
    longint maxVal = longint'(n) * ((longint'(1) << w) - 1);
    int bits = 0;
    while ((longint'(1) << bits) <= maxVal) bits++;
    return bits;
  endfunction

  // Weighted popcount of one counter cell.
  function automatic logic [3:0] gpcEval(input int g, input logic [5:0] dots);
    int k0 = libRank0(g);
    int k1 = libRank1(g);
    int acc = 0;
    for (int i = 0; i < 6; i++) begin
      if (i < k0) acc += int'(dots[i]);
      else if (i < k0 + k1) acc += 2 * int'(dots[i]);
    end
    return acc[3:0];
  endfunction

  // Tallest column with at least three dots left; returns col*8+shape or -1.
  function automatic int pickCell(input heightArr_t rem, input int cols);
    int best = -1;
    int bestH = 2;
    int shape = LIB_SIZE - 1;
    for (int c = 0; c < cols; c++)
      if (int'(rem[c]) > bestH) begin
        best = c;
        bestH = int'(rem[c]);
      end
    if (best < 0) return -1;
    for (int k = LIB_SIZE - 1; k >= 0; k--)
      if (int'(rem[best]) >= libRank0(k) &&
          (libRank1(k) == 0 || (best + 1 < cols && int'(rem[best+1]) >= libRank1(k))))
        shape = k;
    return best * 8 + shape;
  endfunction

  function automatic heightArr_t nextHeights(input heightArr_t h, input int cols);
    heightArr_t rem = h;
    heightArr_t nh = '0;
    int pick = pickCell(rem, cols);
    while (pick >= 0) begin
      int col = pick / 8;
      int g = pick % 8;
      rem[col] = rem[col] - 8'(libRank0(g));
      if (libRank1(g) > 0) rem[col+1] = rem[col+1] - 8'(libRank1(g));
      for (int j = 0; j < libOuts(g); j++)
        if (col + j < cols) nh[col+j] = nh[col+j] + 8'd1;
      pick = pickCell(rem, cols);
    end
    for (int c = 0; c < cols; c++) nh[c] = nh[c] + rem[c];
    return nh;
  endfunction

  function automatic int maxHeight(input heightArr_t h, input int cols);
    int m = 0;
    for (int c = 0; c < cols; c++) if (int'(h[c]) > m) m = int'(h[c]);
    return m;
  endfunction

  function automatic heightArr_t heightsAt(input int n, input int w, input int stage);
    int cols = sumWidth(n, w);
    heightArr_t h = '0;
    for (int c = 0; c < w; c++) h[c] = 8'(n);
    for (int s = 0; s < stage; s++) h = nextHeights(h, cols);
    return h;
  endfunction

  function automatic int numStages(input int n, input int w);
    int cols = sumWidth(n, w);
    heightArr_t h = heightsAt(n, w, 0);
    int s = 0;
    while (maxHeight(h, cols) > 3 && s < 40) begin
      h = nextHeights(h, cols);
      s++;
    end
    return s;
  endfunction

endpackage

// File: rtl/gpcStage.sv
`timescale 1ns/1ps
module gpcStage
  import gpcTreePkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  parameter int STAGE = 0
) (
  input  logic [sumWidth(N, W)-1:0][N+1:0] colIn,
  output logic [sumWidth(N, W)-1:0][N+1:0] colOut
);

  localparam int COLS = sumWidth(N, W);
  localparam int MAXH = N + 2;
  localparam int ITER = COLS * MAXH / 3 + 1;

  always_comb begin
    heightArr_t rem;
    heightArr_t nh;
    int pick;
    int col;
    int g;
    int k0;
    int k1;
    logic [5:0] dots;
    logic [3:0] res;
    rem = heightsAt(N, W, STAGE);
    nh = '0;
    colOut = '0;
    for (int it = 0; it < ITER; it++) begin
      pick = pickCell(rem, COLS);
      col = 0;
      g = 0;
      k0 = 0;
      k1 = 0;
      dots = '0;
      res = '0;
      if (pick >= 0) begin
        col = pick / 8;
        g = pick % 8;
        k0 = libRank0(g);
        k1 = libRank1(g);
        // Take dots from the top of each column stack.
        for (int i = 0; i < 6; i++) begin
          if (i < k0) dots[i] = colIn[col][int'(rem[col]) - 1 - i];
          else if (i < k0 + k1) dots[i] = colIn[col+1][int'(rem[col+1]) - 1 - (i - k0)];
        end
        rem[col] = rem[col] - 8'(k0);
        if (k1 > 0) rem[col+1] = rem[col+1] - 8'(k1);
        res = gpcEval(g, dots);
        for (int j = 0; j < 4; j++)
          if (j < libOuts(g) && col + j < COLS && int'(nh[col+j]) < MAXH) begin
            colOut[col+j][int'(nh[col+j])] = res[j];
            nh[col+j] = nh[col+j] + 8'd1;
          end
      end
    end
    // Uncovered dots pass through to the same column.
    for (int c = 0; c < COLS; c++)
      for (int i = 0; i < MAXH; i++)
        if (i < int'(rem[c]) && int'(nh[c]) + i < MAXH)
          colOut[c][int'(nh[c]) + i] = colIn[c][i];
  end

endmodule

// File: rtl/ternaryAdd.sv
`timescale 1ns/1ps
module ternaryAdd #(
  parameter int WIDTH = 11
) (
  input  logic [WIDTH-1:0] rowA,
  input  logic [WIDTH-1:0] rowB,
  input  logic [WIDTH-1:0] rowC,
  output logic [WIDTH-1:0] total
);
  assign total = rowA + rowB + rowC;
endmodule

// File: rtl/gpcCtrl.sv
`timescale 1ns/1ps
module gpcCtrl
  import gpcTreePkg::*;
(
  input  logic        loadEn,
  output treeStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.capture = loadEn;
  end
endmodule

// File: rtl/gpcDatapath.sv
`timescale 1ns/1ps
module gpcDatapath
  import gpcTreePkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  treeStrobe_t               strobe,
  input  logic [N*W-1:0]            operands,
  output logic [sumWidth(N, W)-1:0] sumNow,
  output logic [sumWidth(N, W)-1:0] sumReg
);

  localparam int SUMW = sumWidth(N, W);
  localparam int COLS = SUMW;
  localparam int MAXH = N + 2;
  localparam int NSTAGE = numStages(N, W);

  logic [COLS-1:0][MAXH-1:0] dotsIn;
  logic [COLS-1:0][MAXH-1:0] tree [NSTAGE+1];
  logic [SUMW-1:0] rowA, rowB, rowC;

  always_comb begin
    dotsIn = '0;
    for (int c = 0; c < W; c++)
      for (int k = 0; k < N; k++)
        dotsIn[c][k] = operands[k*W + c];
  end

  assign tree[0] = dotsIn;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    gpcStage #(.N(N), .W(W), .STAGE(s)) u_stage (
      .colIn (tree[s]),
      .colOut(tree[s+1])
    );
  end

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      rowA[c] = tree[NSTAGE][c][0];
      rowB[c] = tree[NSTAGE][c][1];
      rowC[c] = tree[NSTAGE][c][2];
    end
  end

  ternaryAdd #(.WIDTH(SUMW)) u_final (
    .rowA (rowA),
    .rowB (rowB),
    .rowC (rowC),
    .total(sumNow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sumReg <= '0;
    else if (strobe.capture) sumReg <= sumNow;
  end

  // Checks beside the tree
  logic [SUMW-1:0] refSum;
  logic extraDots;
  logic stageMismatch;

  always_comb begin
    longint acc;
    longint val0;
    longint valS;
    acc = 0;
    for (int k = 0; k < N; k++) acc += longint'(operands[k*W +: W]);
    refSum = acc[SUMW-1:0];
    extraDots = 1'b0;
    for (int c = 0; c < COLS; c++)
      for (int i = 3; i < MAXH; i++) extraDots = extraDots | tree[NSTAGE][c][i];
    val0 = 0;
    for (int c = 0; c < COLS; c++)
      for (int i = 0; i < MAXH; i++) val0 += longint'(tree[0][c][i]) << c;
    stageMismatch = 1'b0;
    for (int s = 1; s <= NSTAGE; s++) begin
      valS = 0;
      for (int c = 0; c < COLS; c++)
        for (int i = 0; i < MAXH; i++) valS += longint'(tree[s][c][i]) << c;
      if (valS != val0) stageMismatch = 1'b1;
    end
  end

  assert_sum_exact_R1: assert property (@(posedge clk) disable iff (!rstN)
    sumNow == refSum);
  assert_stage_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stageMismatch);
  assert_three_rows_R6: assert property (@(posedge clk) disable iff (!rstN)
    !extraDots);
  assert_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> sumReg == $past(sumNow));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(sumReg));

endmodule

// File: rtl/adderTree.sv
`timescale 1ns/1ps
module adderTree
  import gpcTreePkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [N*W-1:0]            operands,
  input  logic                      loadEn,
  output logic [sumWidth(N, W)-1:0] sumNow,
  output logic [sumWidth(N, W)-1:0] sumReg
);

  treeStrobe_t strobe;

  gpcCtrl u_ctrl (
    .loadEn(loadEn),
    .strobe(strobe)
  );

  gpcDatapath #(.N(N), .W(W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .operands(operands),
    .sumNow  (sumNow),
    .sumReg  (sumReg)
  );

endmodule

// File: tb/test_adderTree.sv
`timescale 1ns/1ps
module test_adderTree;
  import gpcTreePkg::*;

  localparam int N = 8;
  localparam int W = 8;
  localparam int SUMW = $clog2(N * (2**W - 1) + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N*W-1:0] operands = '0;
  logic loadEn = 1'b0;
  logic [SUMW-1:0] sumNow;
  logic [SUMW-1:0] sumReg;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adderTree #(.N(N), .W(W)) i_adderTree (
    .clk(clk), .rstN(rstN), .operands(operands), .loadEn(loadEn),
    .sumNow(sumNow), .sumReg(sumReg)
  );

  // Shape table from R3
  int shapeK0 [6] = '{6, 5, 3, 4, 5, 3};
  int shapeK1 [6] = '{0, 1, 2, 1, 0, 0};
  int shapeS  [6] = '{3, 3, 3, 3, 3, 2};

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expSum(input logic [N*W-1:0] v);
    longint acc = 0;
    for (int k = 0; k < N; k++) acc += longint'(v[k*W +: W]);
    return acc;
  endfunction

  task automatic testReset();
    operands = '1;
    loadEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset clears register", longint'(sumReg), 0);
    rstN = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic testCellLibrary();
    for (int g = 0; g < 6; g++) begin
      int ins = shapeK0[g] + shapeK1[g];
      int maxV = shapeK0[g] + 2 * shapeK1[g];
      check("R4 rank0 count", libRank0(g), shapeK0[g]);
      check("R4 rank1 count", libRank1(g), shapeK1[g]);
      check("R4 output count", libOuts(g), shapeS[g]);
      check("R4 limits", longint'(ins <= 6 && shapeK0[g] >= 2 && shapeS[g] < ins &&
                                  (1 << shapeS[g]) > maxV), 1);
      for (int p = 0; p < 64; p++) begin
        logic [5:0] pat = 6'(p);
        int e = 0;
        for (int i = 0; i < 6; i++) begin
          if (i < shapeK0[g]) e += int'(pat[i]);
          else if (i < ins) e += 2 * int'(pat[i]);
          else pat[i] = 1'b0;
        end
        check("R3 cell weighted count", longint'(gpcEval(g, pat)), e);
      end
    end
  endtask

  task automatic testStagePlan();
    int cols = sumWidth(N, W);
    int ns = numStages(N, W);
    heightArr_t h = heightsAt(N, W, ns);
    int m = 0;
    for (int c = 0; c < cols; c++) if (int'(h[c]) > m) m = int'(h[c]);
    check("R6 final rows at most three", longint'(m <= 3), 1);
    check("R6 at least one stage", longint'(ns >= 1), 1);
  endtask

  task automatic testZeroAndOnes();
    operands = '0;
    #1;
    check("R1 zero operands", longint'(sumNow), 0);
    operands = '1;
    #1;
    check("R10 all ones", longint'(sumNow), 2040);
    check("R10 width", SUMW, 11);
  endtask

  task automatic testWalking();
    for (int k = 0; k < N; k++)
      for (int b = 0; b < W; b++) begin
        operands = '0;
        operands[k*W + b] = 1'b1;
        #1;
        check("R1 walking bit", longint'(sumNow), longint'(1) << b);
      end
  endtask

  task automatic testRandom();
    for (int r = 0; r < 200; r++) begin
      for (int k = 0; k < N; k++) operands[k*W +: W] = W'($urandom);
      #1;
      check("R1,R5 random operands", longint'(sumNow), expSum(operands));
    end
    for (int k = 0; k < N; k++) operands[k*W +: W] = (k % 2 == 0) ? '1 : '0;
    #1;
    check("R5 alternating operands", longint'(sumNow), expSum(operands));
  endtask

  task automatic testCombinational();
    @(negedge clk);
    operands = '0;
    operands[7:0] = 8'd200;
    operands[15:8] = 8'd55;
    #1;
    check("R2 same-cycle sum", longint'(sumNow), 255);
    operands[23:16] = 8'd1;
    #1;
    check("R2 update before edge", longint'(sumNow), 256);
  endtask

  task automatic testLoadHold();
    logic [N*W-1:0] first;
    longint held;
    @(negedge clk);
    for (int k = 0; k < N; k++) first[k*W +: W] = W'(17 * k + 3);
    operands = first;
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    held = expSum(first);
    check("R7 load captures sum", longint'(sumReg), held);
    operands = '1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 hold while load low", longint'(sumReg), held);
      operands = operands - 1;
    end
    operands = '1;
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    check("R7 load all ones", longint'(sumReg), 2040);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    testReset();
    testCellLibrary();
    testStagePlan();
    testZeroAndOnes();
    testWalking();
    testRandom();
    testCombinational();
    testLoadHold();
    done = 1'b1;
    finishRun();
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule